// File: doc/BRIEF.md
# SPI Master Byte Exchange Engine

This block is the serial core of an SPI master. Software configures the clock mode, bit order, chip-select behaviour and a receive-discard option through a single control word. Writing that word with its start bit set begins an exchange of a programmed number of 8-bit bytes. Outgoing bytes are taken from the read port of an external transmit FIFO and shifted out on `mosi`. Incoming bits on `miso` are assembled into bytes and offered to the write port of an external receive FIFO.

The total length of the exchange comes from a 24-bit burst count. A second 24-bit count says how many of the leading bytes carry real transmit data. Once that count runs out, the engine sends 0x00 filler bytes until the burst count is reached. The serial clock rate comes from an external half-period enable, `half_tick`. A one-cycle `xfer_done` pulse marks the end of the exchange. Chip select is either sequenced by the engine or set directly by software.

Top module: `spi_xfer_engine`

## Requirements
- R1: The control readback holds CPHA in bit 0, CPOL in bit 1, chip-select polarity in bit 2, the line select in bits 5:4, manual mode in bit 6, the manual level in bit 7, receive-discard in bit 8 and LSB-first in bit 12; every other bit below 31 reads 0, and all fields read 0 after reset. Writing bit 31 as 1 while idle starts an exchange. Bit 31 reads 1 while the exchange runs, and it falls in the same cycle that `xfer_done` pulses.
- R2: An exchange shifts exactly burst-count bytes, with 16 `sclk` transitions per byte. A start with a burst count of 0 produces `xfer_done` on the cycle after the write, with no `sclk` activity and no busy phase.
- R3: The first min(transmit count, burst count) bytes are popped from the transmit FIFO and sent. Every later byte of the burst is sent as 0x00 without a pop.
- R4: With bit 12 clear, each byte is sent and assembled MSB first. With bit 12 set, it is LSB first.
- R5: `sclk` idles at the CPOL level and changes only after a `half_tick`. With CPHA 0, `miso` is sampled on the first (leading) transition of each bit. With CPHA 1, it is sampled on the second (trailing) transition.
- R6: With bit 8 set, bytes received while real transmit data is sent are not written to the receive FIFO. Bytes received during the 0x00 filler part are always written.
- R7: When real data is still owed and the transmit FIFO is empty, the engine does not pop. It holds `sclk` at idle and resumes when data arrives.
- R8: In automatic mode (bit 6 clear), the selected line is at its active level from the start cycle until the cycle `xfer_done` pulses, and all other lines stay idle. A line is active low when bit 2 is set and active high when bit 2 is clear.
- R9: In manual mode (bit 6 set), the selected line carries the level of bit 7 and the other lines sit at the idle level.
- R10: If the receive FIFO is full when a byte must be stored, the byte is dropped and `rx_ovf` pulses for one cycle instead of `rxf_push`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data; bit 31 starts an exchange |
| ctl_rdata | output | 32 | Control word readback; bit 31 is busy |
| burst_cnt | input | 24 | Total bytes to exchange, sampled at start |
| txd_cnt | input | 24 | Leading bytes that carry real transmit data, sampled at start |
| half_tick | input | 1 | Serial half-period enable from the divider |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_rdata | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Pop the transmit FIFO head |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Write `rxf_wdata` into the receive FIFO |
| rxf_wdata | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip-select lines |
| xfer_done | output | 1 | One-cycle pulse when the exchange ends |
| rx_ovf | output | 1 | One-cycle pulse when a received byte is dropped |

## Verification
Each output is due at a fixed point after its cause:
- `txf_pop` is combinational in the load cycle.
- `rxf_push` and `rx_ovf` are combinational in the cycle of the sixteenth `half_tick` of a byte.
- `sclk` moves in the cycle after each `half_tick`.
- `xfer_done` and the fall of busy come together one cycle after the trailing `half_tick`.

The bench drives inputs just after the rising edge and samples every output at the falling edge, so each event is seen in exactly the cycle it is valid. The slave model captures `mosi` only on the transitions that R5 names as sampling edges and changes `miso` only after them. Totals such as byte contents, pop counts and edge counts are compared once `xfer_done` has been seen.

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int DW = 8,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [31:0]   ctl_wdata,
  output logic [31:0]   ctl_rdata,
  input  logic [CW-1:0] burst_cnt,
  input  logic [CW-1:0] txd_cnt,
  input  logic          half_tick,
  input  logic          txf_empty,
  input  logic [DW-1:0] txf_rdata,
  output logic          txf_pop,
  input  logic          rxf_full,
  output logic          rxf_push,
  output logic [DW-1:0] rxf_wdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    cs,
  output logic          xfer_done,
  output logic          rx_ovf
);
  localparam int PW = $clog2(2*DW);
  localparam logic [PW-1:0] K_LAST = PW'(2*DW-1);
  localparam logic [30:0] CTL_MASK = 31'h0000_11F7;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOAD, S_SHIFT, S_TRAIL} st_t;
  st_t st;

  logic [30:0]   ctl_q;
  logic [CW-1:0] burst_left, tx_left;
  logic [DW-1:0] txs, rxs;
  logic [PW-1:0] k;
  logic          tgl, real_byte, done_q;

  wire cpha = ctl_q[0];
  wire cpol = ctl_q[1];
  wire spol = ctl_q[2];
  wire [1:0] sel = ctl_q[5:4];
  wire man  = ctl_q[6];
  wire mlvl = ctl_q[7];
  wire dhb  = ctl_q[8];
  wire lsb  = ctl_q[12];

  wire busy       = (st != S_IDLE);
  wire start      = ctl_we & ctl_wdata[31] & ~busy;
  wire tick_shift = (st == S_SHIFT) & half_tick;
  wire last       = (k == K_LAST);
  wire samp       = tick_shift & (~k[0] ^ cpha);
  wire adv        = tick_shift & ~samp & ~(cpha ? (k == '0) : last);
  wire byte_end   = tick_shift & last;
  wire keep       = ~(dhb & real_byte);
  wire has_real   = (tx_left != '0);

  wire [DW-1:0] rx_next = lsb ? {miso, rxs[DW-1:1]} : {rxs[DW-2:0], miso};

  assign ctl_rdata = {busy, ctl_q};
  assign txf_pop   = (st == S_LOAD) & has_real & ~txf_empty;
  assign rxf_push  = byte_end & keep & ~rxf_full;
  assign rx_ovf    = byte_end & keep & rxf_full;
  assign rxf_wdata = cpha ? rx_next : rxs;
  assign mosi      = lsb ? txs[0] : txs[DW-1];
  assign sclk      = cpol ^ tgl;
  assign xfer_done = done_q;

  wire act_lvl = man ? mlvl : (busy ? ~spol : spol);

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign cs[i] = (sel == 2'(i)) ? act_lvl : spol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ctl_q      <= '0;
      burst_left <= '0;
      tx_left    <= '0;
      txs        <= '0;
      rxs        <= '0;
      k          <= '0;
      tgl        <= 1'b0;
      real_byte  <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ctl_we) ctl_q <= ctl_wdata[30:0] & CTL_MASK;
      case (st)
        S_IDLE: if (start) begin
          if (burst_cnt == '0) begin
            done_q <= 1'b1;
          end else begin
            burst_left <= burst_cnt;
            tx_left    <= txd_cnt;
            st         <= S_LEAD;
          end
        end
        S_LEAD: if (half_tick) st <= S_LOAD;
        S_LOAD: begin
          if (has_real) begin
            if (!txf_empty) begin
              txs       <= txf_rdata;
              tx_left   <= tx_left - 1'b1;
              real_byte <= 1'b1;
              k         <= '0;
              st        <= S_SHIFT;
            end
          end else begin
            txs       <= '0;
            real_byte <= 1'b0;
            k         <= '0;
            st        <= S_SHIFT;
          end
        end
        S_SHIFT: if (half_tick) begin
          tgl <= ~tgl;
          k   <= k + 1'b1;
          if (samp) rxs <= rx_next;
          if (adv)  txs <= lsb ? (txs >> 1) : (txs << 1);
          if (last) begin
            burst_left <= burst_left - 1'b1;
            st         <= (burst_left == CW'(1)) ? S_TRAIL : S_LOAD;
          end
        end
        S_TRAIL: if (half_tick) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_we,
  input logic [31:0] ctl_rdata,
  input logic        half_tick,
  input logic        txf_empty,
  input logic        txf_pop,
  input logic        rxf_full,
  input logic        rxf_push,
  input logic        rx_ovf,
  input logic        sclk,
  input logic [3:0]  cs,
  input logic        xfer_done
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !ctl_rdata[31]);                                    // R1
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> !rxf_full);                                          // R10
  AST_OVF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf |-> (rxf_full && !rxf_push));                              // R10
  AST_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> !txf_empty);                                          // R7
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[31] |-> (sclk == ctl_rdata[1]));                       // R5
  AST_SCLK_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && !ctl_we) |=> $stable(sclk));                       // R5
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs ^ {4{ctl_rdata[2]}}) <= 1);                         // R8
endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
  .half_tick(half_tick), .txf_empty(txf_empty), .txf_pop(txf_pop),
  .rxf_full(rxf_full), .rxf_push(rxf_push), .rx_ovf(rx_ovf),
  .sclk(sclk), .cs(cs), .xfer_done(xfer_done)
);

// File: tb/spi_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module spi_xfer_engine_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        ctl_we = 0;
  logic [31:0] ctl_wdata = 0, ctl_rdata;
  logic [23:0] burst_cnt = 0, txd_cnt = 0;
  logic        half_tick = 0, txf_empty = 1, txf_pop, rxf_full = 0, rxf_push;
  logic [7:0]  txf_rdata = 0, rxf_wdata;
  logic        sclk, mosi, miso = 0, xfer_done, rx_ovf;
  logic [3:0]  cs;

  spi_xfer_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .burst_cnt(burst_cnt), .txd_cnt(txd_cnt),
    .half_tick(half_tick), .txf_empty(txf_empty), .txf_rdata(txf_rdata),
    .txf_pop(txf_pop), .rxf_full(rxf_full), .rxf_push(rxf_push),
    .rxf_wdata(rxf_wdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs),
    .xfer_done(xfer_done), .rx_ovf(rx_ovf)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int div = 2, tcnt = 0, rx_cap = 1000;
  bit t_cpha, t_cpol, t_lsb, t_spol, cs_watch = 0, pop_pend = 0, prev_sclk = 0;
  int t_sel;
  logic [7:0] sl_sh, salt;
  int bc, sidx, edges, pops, ovf, done_seen, done_bad, cs_bad;
  logic [7:0] txq[$], rxq[$], got[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sbyte(input int n);
    return 8'((n * 53) + salt);
  endfunction

  function automatic logic sbit(input int n, input int b);
    logic [7:0] v = sbyte(n);
    return t_lsb ? v[b] : v[7-b];
  endfunction

  function automatic void refresh_tx();
    txf_empty = (txq.size() == 0);
    txf_rdata = txf_empty ? 8'h00 : txq[0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d expected < 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
    #1;
    if (pop_pend) begin
      if (txq.size() > 0) void'(txq.pop_front());
      pops++;
      pop_pend = 0;
    end
    half_tick = (tcnt >= div - 1);
    tcnt = half_tick ? 0 : tcnt + 1;
    refresh_tx();
  end

  always @(negedge clk) if (rst_n) begin
    if (sclk !== prev_sclk) begin
      edges++;
      if ((prev_sclk == t_cpol) != t_cpha) begin
        sl_sh = t_lsb ? {mosi, sl_sh[7:1]} : {sl_sh[6:0], mosi};
        bc++;
        if (bc == 8) begin got.push_back(sl_sh); bc = 0; sidx++; end
        miso = sbit(sidx, bc);
      end
      prev_sclk = sclk;
    end
    if (rxf_push) rxq.push_back(rxf_wdata);
    if (rx_ovf) ovf++;
    if (xfer_done) begin done_seen++; if (ctl_rdata[31]) done_bad++; end
    if (cs_watch) begin
      for (int i = 0; i < 4; i++) begin
        logic e;
        e = (i == t_sel && ctl_rdata[31]) ? ~t_spol : t_spol;
        if (cs[i] !== e) cs_bad++;
      end
    end
    pop_pend = txf_pop;
    rxf_full = (rxq.size() >= rx_cap);
  end

  task automatic wr_ctl(input logic [31:0] v);
    @(posedge clk); #1; ctl_we = 1; ctl_wdata = v;
    @(posedge clk); #1; ctl_we = 0;
  endtask

  function automatic logic [31:0] cfg(bit cpha, bit cpol, bit spol, int sel,
                                      bit man, bit mlvl, bit dhb, bit lsb, bit go);
    return {go, 18'b0, lsb, 3'b0, dhb, mlvl, man, 2'(sel), 1'b0, spol, cpol, cpha};
  endfunction

  task automatic push_tx(input logic [7:0] b);
    @(posedge clk); #2; txq.push_back(b); refresh_tx();
  endtask

  task automatic run_xfer(input bit cpha, input bit cpol, input bit spol, input bit lsb,
                          input bit dhb, input int sel, input int burst, input int txn,
                          input int hold, input int d, input int cap, input string tag);
    logic [7:0] data[$];
    logic [7:0] exp_rx[$];
    int nreal, eovf, w, bad;
    logic [7:0] a, e;
    div = d; rx_cap = cap;
    t_cpha = cpha; t_cpol = cpol; t_lsb = lsb; t_spol = spol; t_sel = sel;
    salt = 8'($urandom);
    txq.delete(); rxq.delete(); got.delete();
    wr_ctl(cfg(cpha, cpol, spol, sel, 0, 0, dhb, lsb, 0));
    repeat (3) @(negedge clk);
    prev_sclk = sclk; bc = 0; sidx = 0; sl_sh = 0; miso = sbit(0, 0);
    edges = 0; pops = 0; ovf = 0; done_seen = 0; done_bad = 0; cs_bad = 0;
    cs_watch = 1;
    chk(sclk == cpol, {"R5 idle level ", tag}, sclk, cpol);
    for (int i = 0; i < txn; i++) data.push_back(8'($urandom));
    for (int i = 0; i < hold; i++) push_tx(data[i]);
    burst_cnt = 24'(burst); txd_cnt = 24'(txn);
    wr_ctl(cfg(cpha, cpol, spol, sel, 0, 0, dhb, lsb, 1));
    @(negedge clk);
    chk(ctl_rdata[31] == 1'b1, {"R1 busy readback ", tag}, ctl_rdata[31], 1);
    if (hold < txn) begin
      w = 0;
      while (pops < hold && w < 5000) begin @(negedge clk); w++; end
      repeat (300) @(negedge clk);
      chk(ctl_rdata[31] && sclk == cpol && edges == 16*hold && pops == hold,
          {"R7 stall holds sclk idle ", tag}, edges, 16*hold);
      for (int i = hold; i < txn; i++) push_tx(data[i]);
    end
    w = 0;
    while (done_seen == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
    cs_watch = 0;
    nreal = (txn < burst) ? txn : burst;
    chk(done_seen == 1 && done_bad == 0, {"R1 done with busy low ", tag}, done_seen, 1);
    chk(edges == 16*burst, {"R2 sclk transitions ", tag}, edges, 16*burst);
    chk(pops == nreal, {"R3 pop count ", tag}, pops, nreal);
    bad = (got.size() != burst); a = 0; e = 0;
    for (int n = 0; n < burst && !bad; n++) begin
      e = (n < nreal) ? data[n] : 8'h00;
      a = got[n];
      if (a != e) bad = 1;
    end
    chk(!bad, {"R3 R4 mosi bytes ", tag}, a, e);
    eovf = 0;
    for (int n = 0; n < burst; n++)
      if (!(dhb && n < nreal)) begin
        if (exp_rx.size() < cap) exp_rx.push_back(sbyte(n)); else eovf++;
      end
    bad = (rxq.size() != exp_rx.size()); a = 8'(rxq.size()); e = 8'(exp_rx.size());
    for (int n = 0; n < exp_rx.size() && !bad; n++) begin
      a = rxq[n]; e = exp_rx[n];
      if (a != e) bad = 1;
    end
    chk(!bad, {"R4 R5 R6 received bytes ", tag}, a, e);
    chk(ovf == eovf, {"R10 overflow pulses ", tag}, ovf, eovf);
    chk(cs_bad == 0, {"R8 auto chip select ", tag}, cs_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(ctl_rdata == 32'h0 && sclk == 0 && cs == 4'h0 && !xfer_done && !txf_pop && !rxf_push,
        "R1 reset state", ctl_rdata, 0);

    wr_ctl(32'h7FFF_FFFF);
    @(negedge clk);
    chk(ctl_rdata == 32'h0000_11F7, "R1 field readback", ctl_rdata, 32'h11F7);
    chk(cs == 4'b1111, "R9 manual level high, active-low lines", cs, 4'b1111);
    wr_ctl(32'h7FFF_FF7F);
    @(negedge clk);
    chk(cs == 4'b0111, "R9 manual level low on line 3", cs, 4'b0111);
    wr_ctl(32'h0000_00D0);
    @(negedge clk);
    chk(cs == 4'b0010, "R9 manual line 1 high", cs, 4'b0010);
    wr_ctl(32'h0);

    done_seen = 0; edges = 0; prev_sclk = sclk;
    burst_cnt = 0; txd_cnt = 5;
    wr_ctl(32'h8000_0000);
    repeat (3) @(negedge clk);
    chk(done_seen == 1 && edges == 0 && !ctl_rdata[31], "R2 zero burst", done_seen, 1);

    run_xfer(0, 0, 1, 0, 0, 0, 4, 4, 4, 2, 1000, "mode0 msb");
    run_xfer(1, 1, 0, 1, 1, 2, 5, 2, 2, 3, 1000, "mode3 lsb discard");
    run_xfer(1, 0, 1, 0, 1, 1, 3, 0, 0, 1, 1000, "all filler");
    run_xfer(0, 1, 1, 0, 0, 3, 3, 3, 1, 2, 1000, "stall");
    run_xfer(0, 0, 0, 0, 0, 1, 3, 3, 3, 2, 1, "overflow");
    run_xfer(1, 1, 1, 1, 0, 0, 2, 5, 5, 4, 1000, "tx beyond burst");
    for (int i = 0; i < 14; i++) begin
      int b, t;
      b = 1 + int'($urandom % 6);
      t = int'($urandom % (b + 2));
      run_xfer(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               int'($urandom % 4), b, t, t, 1 + int'($urandom % 4),
               ($urandom % 4 == 0) ? 2 : 1000, "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule